// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a bank of 32 general-purpose I/O lines controlled through a small word-addressed register bus. Software sets each line's direction, the value it drives, and whether that value is gated by a slow blink clock. Software can also invert the sense of any input. After synchronisation, every input passes through its polarity inversion, and only that adjusted value is readable and used for interrupts.

Each line can request an interrupt in two ways. A level request follows the adjusted input while the level enable is set. An edge request comes from a sticky cause bit that is set by a rising transition of the adjusted input and cleared by software. The per-line requests are ORed in groups of eight lines, and each group drives its own interrupt output. The block sits between the pad ring and the interrupt controller.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register reads all ones, so every line is an input and `pin_oe` is zero. Output data, blink, polarity, edge cause, edge enable and level enable all read zero, and every `irq_grp` bit is 0.
- R2: Direction lives at byte offset 0x04. A bit value of 1 makes the line an input (`pin_oe` bit 0). A bit value of 0 makes it an output (`pin_oe` bit 1). Writes take effect one cycle after the write strobe.
- R3: Output data lives at offset 0x00. When a line's blink bit is 0, its `pin_out` bit equals its output data bit.
- R4: Blink enable lives at offset 0x08. When a line's blink bit is 1, its `pin_out` bit is the output data bit ANDed with a square wave. The square wave is high for `BLINK_HALF` cycles and low for `BLINK_HALF` cycles.
- R5: Polarity lives at offset 0x0C, and data-in lives at offset 0x10. Each data-in bit is the pin, passed through two synchronizer flops, XORed with its polarity bit. Writes to 0x10 change nothing.
- R6: Level enable lives at offset 0x1C. A line's level request is its data-in bit ANDed with its level enable bit.
- R7: Edge cause lives at offset 0x14, and edge enable lives at offset 0x18. A cause bit is set when the line's data-in value goes from 0 to 1. With polarity 0 this is a rising pin edge; with polarity 1 it is a falling pin edge. A line's edge request is its cause bit ANDed with its edge enable bit.
- R8: Writing to 0x14 clears the cause bits written as 0 and leaves the bits written as 1 unchanged.
- R9: If a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R10: Output `irq_grp[k]` is the OR of the level and edge requests of lines 8k to 8k+7.
- R11: A read strobe returns the addressed register on `bus_rdata` one cycle later. Any other byte offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Value driven onto each pin |
| pin_oe | output | 32 | Output enable for each pin |
| irq_grp | output | 4 | Interrupt per group of eight lines |

## Verification
The two functions that can collide are hardware edge capture into a cause bit and a software write that clears that bit. The bench times a pin transition so that the synchronised edge reaches the cause register on the same clock edge as a write of zero to the cause offset. It then reads the cause back and expects the bit to still be set; a second, quiet clear must then return zero. Random rounds vary polarity, pins and both enables, and compare the cause, data-in and group outputs against values the bench computes itself.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    parameter int unsigned GB_LINES  = 32;
    parameter int unsigned GB_ADDR_W = 8;

    localparam logic [GB_ADDR_W-1:0] OFF_DOUT  = 8'h00;
    localparam logic [GB_ADDR_W-1:0] OFF_DIR   = 8'h04;
    localparam logic [GB_ADDR_W-1:0] OFF_BLINK = 8'h08;
    localparam logic [GB_ADDR_W-1:0] OFF_POL   = 8'h0C;
    localparam logic [GB_ADDR_W-1:0] OFF_DIN   = 8'h10;
    localparam logic [GB_ADDR_W-1:0] OFF_CAUSE = 8'h14;
    localparam logic [GB_ADDR_W-1:0] OFF_EMASK = 8'h18;
    localparam logic [GB_ADDR_W-1:0] OFF_LMASK = 8'h1C;

    typedef logic [GB_LINES-1:0] lines_t;

    typedef struct packed {
        lines_t dout;
        lines_t dir;
        lines_t blink;
        lines_t pol;
        lines_t cause;
        lines_t emask;
        lines_t lmask;
        lines_t prev;
        lines_t rdata;
    } bank_regs_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
    parameter int unsigned BLINK_HALF = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    localparam int unsigned CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_HALF - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             phase_q, phase_d;

    always_comb begin
        cnt_d   = cnt_q + 1'b1;
        phase_d = phase_q;
        if (cnt_q == LAST) begin
            cnt_d   = '0;
            phase_d = ~phase_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
    parameter int unsigned LINES   = 32,
    parameter int unsigned GROUP_W = 8
) (
    input  logic [LINES-1:0]         line_req_i,
    output logic [LINES/GROUP_W-1:0] grp_o
);
    localparam int unsigned NGRP = LINES / GROUP_W;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_o[g] = |line_req_i[g*GROUP_W +: GROUP_W];
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned BLINK_HALF = 1024,
    parameter int unsigned GROUP_W    = 8,
    localparam int unsigned N         = GB_LINES,
    localparam int unsigned NGRP      = N / GROUP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [GB_ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]         bus_wdata,
    output logic [N-1:0]         bus_rdata,
    input  logic [N-1:0]         pin_in,
    output logic [N-1:0]         pin_out,
    output logic [N-1:0]         pin_oe,
    output logic [NGRP-1:0]      irq_grp
);
    bank_regs_t regs_q, regs_d;
    lines_t     pin_sync;
    lines_t     adj_in;
    lines_t     edge_hit;
    lines_t     line_req;
    logic       blink_phase;

    // Named views of the interrupt state for the bound checker
    lines_t     cause_view, emask_view, lmask_view;

    gpio_sync #(.WIDTH(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (blink_phase)
    );

    assign adj_in   = pin_sync ^ regs_q.pol;
    assign edge_hit = adj_in & ~regs_q.prev;
    assign line_req = (adj_in & regs_q.lmask) | (regs_q.cause & regs_q.emask);

    gpio_irq_agg #(.LINES(N), .GROUP_W(GROUP_W)) u_agg (
        .line_req_i (line_req),
        .grp_o      (irq_grp)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.prev = adj_in;
        if (bus_wr) begin
            case (bus_addr)
                OFF_DOUT:  regs_d.dout  = bus_wdata;
                OFF_DIR:   regs_d.dir   = bus_wdata;
                OFF_BLINK: regs_d.blink = bus_wdata;
                OFF_POL:   regs_d.pol   = bus_wdata;
                OFF_CAUSE: regs_d.cause = regs_q.cause & bus_wdata;
                OFF_EMASK: regs_d.emask = bus_wdata;
                OFF_LMASK: regs_d.lmask = bus_wdata;
                default:   ;
            endcase
        end
        // A fresh edge wins over a clearing write in the same cycle
        regs_d.cause = regs_d.cause | edge_hit;
        if (bus_rd) begin
            case (bus_addr)
                OFF_DOUT:  regs_d.rdata = regs_q.dout;
                OFF_DIR:   regs_d.rdata = regs_q.dir;
                OFF_BLINK: regs_d.rdata = regs_q.blink;
                OFF_POL:   regs_d.rdata = regs_q.pol;
                OFF_DIN:   regs_d.rdata = adj_in;
                OFF_CAUSE: regs_d.rdata = regs_q.cause;
                OFF_EMASK: regs_d.rdata = regs_q.emask;
                OFF_LMASK: regs_d.rdata = regs_q.lmask;
                default:   regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.dir <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata  = regs_q.rdata;
    assign pin_oe     = ~regs_q.dir;
    assign pin_out    = regs_q.dout & ~(regs_q.blink & {N{~blink_phase}});
    assign cause_view = regs_q.cause;
    assign emask_view = regs_q.emask;
    assign lmask_view = regs_q.lmask;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NGRP = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [GB_ADDR_W-1:0] bus_addr,
    input logic [GB_LINES-1:0]  bus_wdata,
    input logic [GB_LINES-1:0]  bus_rdata,
    input logic [GB_LINES-1:0]  pin_oe,
    input logic [NGRP-1:0]      irq_grp,
    input logic [GB_LINES-1:0]  cause_q,
    input logic [GB_LINES-1:0]  emask_q,
    input logic [GB_LINES-1:0]  lmask_q
);
    logic unmapped;
    assign unmapped = !(bus_addr inside {OFF_DOUT, OFF_DIR, OFF_BLINK, OFF_POL,
                                         OFF_DIN, OFF_CAUSE, OFF_EMASK, OFF_LMASK});

    // R1: one cycle into reset, nothing is enabled, so no group requests
    p_rst_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_grp == '0));

    // R2: a direction write shows up inverted on the output enables
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DIR) |=> (pin_oe == ~$past(bus_wdata)));

    // R7: without a write to the cause offset, set cause bits stay set
    p_cause_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFF_CAUSE) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R8: set cause bits written as 1 survive the write
    p_cause_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CAUSE)
        |=> ((cause_q & $past(cause_q & bus_wdata)) == $past(cause_q & bus_wdata)));

    // R10: with both enables clear, no group can request
    p_no_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> (irq_grp == '0));

    // R11: unmapped offsets read back as zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NGRP(NGRP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq_grp   (irq_grp),
    .cause_q   (cause_view),
    .emask_q   (emask_view),
    .lmask_q   (lmask_view)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic [3:0]  irq_grp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.BLINK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_grp(irq_grp)
    );

    function automatic logic [3:0] grp_or(input logic [31:0] v);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |v[g*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, pol, oldp, newp, lm, em, adj, cause_exp;
        int hi0, hi1;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 irq", {28'h0, irq_grp}, 32'h0);
        rd(8'h04, v); chk("R1 dir", v, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R1 dout", v, 32'h0);
        rd(8'h14, v); chk("R1 cause", v, 32'h0);
        rd(8'h18, v); chk("R1 emask", v, 32'h0);
        rd(8'h1C, v); chk("R1 lmask", v, 32'h0);

        // R11 unmapped offsets
        rd(8'h20, v); chk("R11 unmapped 0x20", v, 32'h0);
        rd(8'h02, v); chk("R11 unmapped 0x02", v, 32'h0);

        // R5 writes to data-in are ignored
        pin_in = 32'h00F0_0F0F;
        settle();
        wr(8'h10, 32'hDEAD_BEEF);
        rd(8'h10, v); chk("R5 din ignores write", v, 32'h00F0_0F0F);

        // R9 edge and clearing write in the same cycle
        wr(8'h14, 32'h0);
        rd(8'h14, v); chk("R8 clear all", v, 32'h0);
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h14, v); chk("R9 edge beats clear", v, 32'h0000_0020);
        wr(8'h14, 32'h0);
        rd(8'h14, v); chk("R8 quiet clear", v, 32'h0);

        // R8 write-one keeps, write-zero clears
        pin_in[9] = 1'b1; pin_in[30] = 1'b1;
        settle();
        wr(8'h14, ~32'h0000_0200);
        rd(8'h14, v); chk("R8 partial clear", v, 32'h4000_0000);

        // R4 blink
        wr(8'h04, 32'hFFFF_FFFC);
        wr(8'h00, 32'h0000_0003);
        wr(8'h08, 32'h0000_0001);
        chk("R2 oe low lines", pin_oe, 32'h0000_0003);
        hi0 = 0; hi1 = 0;
        for (int i = 0; i < 2*HALF; i++) begin
            @(negedge clk);
            hi0 += int'(pin_out[0]);
            hi1 += int'(pin_out[1]);
        end
        chk("R4 blink duty", hi0, HALF);
        chk("R3 steady line", hi1, 2*HALF);
        wr(8'h08, 32'h0);

        // Random rounds: R2 R3 R5 R6 R7 R10
        oldp = pin_in;
        for (int it = 0; it < 40; it++) begin
            pol = $urandom;
            wr(8'h0C, pol);
            settle();
            wr(8'h14, 32'h0);
            wr(8'h1C, 32'h0); wr(8'h18, 32'h0);
            newp = $urandom;
            if (it % 4 == 0) newp = ~oldp;
            @(negedge clk);
            pin_in = newp;
            settle();
            lm = $urandom & $urandom;
            em = (it % 5 == 0) ? 32'h0 : $urandom & $urandom;
            wr(8'h1C, lm);
            wr(8'h18, em);
            adj = newp ^ pol;
            cause_exp = adj & ~(oldp ^ pol);
            @(negedge clk);
            chk("R10 group irq", {28'h0, irq_grp}, {28'h0, grp_or((adj & lm) | (cause_exp & em))});
            if (em == 32'h0) chk("R6 level only", {28'h0, irq_grp}, {28'h0, grp_or(adj & lm)});
            rd(8'h10, v); chk("R5 data-in", v, adj);
            rd(8'h14, v); chk("R7 cause", v, cause_exp);
            v = $urandom;
            wr(8'h04, v);
            chk("R2 oe", pin_oe, ~v);
            v = $urandom;
            wr(8'h00, v);
            chk("R3 pin_out", pin_out, v);
            oldp = newp;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule